// File: doc/BRIEF.md
# Dual-Plane Pixel Scanout Selector

This stage sits in a framebuffer scanout path. For every pixel position it receives three values at once: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word decides the pixel's source. When that byte carries the direct tag, the colour comes from the direct word. That word is stored blue-first, so the stage reorders it to red-first. For every other tag value, the index is sent out on a combinational palette read port. The colour returned on that port becomes the pixel.

Lines in memory have a fixed stride of `STRIDE` pixels, and every stride position is fed into the stage. The stage counts positions itself and drops every pixel at or beyond the runtime `lineWidth`. Surviving pixels leave as a 24-bit colour stream with valid/ready handshaking and start-of-line / end-of-line flags. The pipeline has two register stages, and a low `outReady` stalls the whole stage.

Top module: `plane_scan_selector`

## Requirements
- R1: After reset `outValid` is low, `inReady` is high and the column count starts at position 0.
- R2: A pixel whose control word has bits 31:24 equal to 0x03 is direct. The direct word holds blue in bits 7:0, green in 15:8 and red in 23:16. The stage outputs red in `outRgb[7:0]`, green in `[15:8]` and blue in `[23:16]`. Bits 31:24 of the direct word and bits 23:0 of the control word have no effect.
- R3: For every other pixel, the 8-bit index is presented on `palIndex`. The 24-bit value returned on `palRgb` is output unchanged, in the same byte layout as R2.
- R4: Every control top byte other than 0x03 (for example 0x00, 0x02, 0x83, 0xFF) selects the palette path and raises no flag.
- R5: With `outReady` high, a pixel accepted on clock edge k is on the outputs after edge k+1, and `outValid` is still low after edge k.
- R6: While `outValid` is high and `outReady` is low, `outRgb`, `outSol` and `outEol` hold their values, `outValid` stays high and `inReady` is low.
- R7: Each accepted input advances a column count from 0 to STRIDE-1, after which it wraps to 0. Only columns below `lineWidth` produce output, in input order.
- R8: `outSol` is high on column 0 and `outEol` on column `lineWidth`-1. Both are high together when `lineWidth` is 1.
- R9: With `lineWidth` equal to STRIDE, every column is emitted and `outEol` marks column STRIDE-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineWidth | input | COL_W+1 | Active pixels per line, 1..STRIDE |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Stage accepts the input pixel this cycle |
| inIndex | input | 8 | Indexed-plane value |
| inDirect | input | 32 | Direct-plane word, blue in low byte |
| inCtrl | input | 32 | Control-plane word, tag in bits 31:24 |
| palIndex | output | 8 | Palette read address |
| palRgb | input | 24 | Palette read data, combinational |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Downstream accepts the output pixel |
| outRgb | output | 24 | Pixel colour, red in low byte |
| outSol | output | 1 | First pixel of a line |
| outEol | output | 1 | Last active pixel of a line |

## Verification
The bench builds the stage with STRIDE set to 16 instead of 1024. Full lines then take a few dozen cycles, so the column wrap, the dropped tail past `lineWidth` and the full-width case with `outEol` on the last stride column can all be reached many times. Widths of 1, 5, 10 and 16 cover coincident flags, narrow lines and the full stride. A stall held across a full pipeline shows the hold behaviour and the back-pressure on `inReady`.

// File: rtl/plane_scan_pkg.sv
package plane_scan_pkg;
  // Control-word top byte that marks a pixel as direct colour
  localparam logic [7:0] DIRECT_TAG = 8'h03;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;   // whole pipeline moves one step
    logic capture;   // stage 1 loads a kept input pixel
  } scanStrobe_t;
endpackage

// File: rtl/plane_scan_ctrl.sv
module plane_scan_ctrl
  import plane_scan_pkg::*;
#(
  parameter int STRIDE = 1024,
  localparam int COL_W = $clog2(STRIDE),
  localparam int WIDTH_W = COL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH_W-1:0] lineWidth,
  input  logic               inValid,
  output logic               inReady,
  input  logic               outReady,
  output logic               outValid,
  output logic               outSol,
  output logic               outEol,
  output scanStrobe_t        strobe
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(STRIDE - 1);

  logic [COL_W-1:0] colCount;
  logic v1, v2, sol1, sol2, eol1, eol2;
  logic advance, accept, keep;

  assign advance = !v2 || outReady;
  assign accept  = inValid && advance;
  assign keep    = {1'b0, colCount} < lineWidth;

  assign inReady        = advance;
  assign strobe.advance = advance;
  assign strobe.capture = accept && keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colCount <= '0;
      v1 <= 1'b0; v2 <= 1'b0;
      sol1 <= 1'b0; sol2 <= 1'b0;
      eol1 <= 1'b0; eol2 <= 1'b0;
    end else if (advance) begin
      v1   <= accept && keep;
      sol1 <= colCount == '0;
      eol1 <= {1'b0, colCount} == lineWidth - WIDTH_W'(1);
      v2   <= v1;
      sol2 <= sol1;
      eol2 <= eol1;
      if (accept) colCount <= (colCount == LAST_COL) ? '0 : colCount + COL_W'(1);
    end
  end

  assign outValid = v2;
  assign outSol   = v2 && sol2;
  assign outEol   = v2 && eol2;

  // R6: a stalled output keeps its flags and blocks new input
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outSol) && $stable(outEol));
  p_stall_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |-> !inReady);
  // R7: column count wraps at the stride
  p_col_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && colCount == LAST_COL |=> colCount == '0);
  // R7: columns past the active width never enter stage 1
  p_drop_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && ({1'b0, colCount} >= lineWidth) |=> !v1);
  // R5: a filled stage 1 reaches the output on the next advancing edge
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    v1 && advance |=> outValid);
endmodule

// File: rtl/plane_scan_datapath.sv
module plane_scan_datapath
  import plane_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  scanStrobe_t strobe,
  input  logic [7:0]  inIndex,
  input  logic [31:0] inDirect,
  input  logic [31:0] inCtrl,
  output logic [7:0]  palIndex,
  input  logic [23:0] palRgb,
  output logic [23:0] outRgb
);
  logic [7:0]  idx1;
  logic [23:0] bgr1;
  logic        direct1;
  logic [23:0] rgbSel;
  logic [23:0] rgb2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx1 <= '0; bgr1 <= '0; direct1 <= 1'b0;
    end else if (strobe.capture) begin
      idx1    <= inIndex;
      bgr1    <= inDirect[23:0];
      direct1 <= inCtrl[31:24] == DIRECT_TAG;
    end
  end

  assign palIndex = idx1;

  // Reorder blue-first storage into red-in-low-byte output
  assign rgbSel = direct1 ? {bgr1[7:0], bgr1[15:8], bgr1[23:16]} : palRgb;

  always_ff @(posedge clk) begin
    if (!rst_n) rgb2 <= '0;
    else if (strobe.advance) rgb2 <= rgbSel;
  end

  assign outRgb = rgb2;

  // R6: colour holds while the pipeline is frozen
  p_rgb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance |=> $stable(outRgb));
  // R2: the direct tag marks stage 1 as direct
  p_tag_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture && inCtrl[31:24] == DIRECT_TAG |=> direct1);
  // R4: any other tag selects the palette
  p_tag_palette_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture && inCtrl[31:24] != DIRECT_TAG |=> !direct1 && palIndex == $past(inIndex));
endmodule

// File: rtl/plane_scan_selector.sv
module plane_scan_selector
  import plane_scan_pkg::*;
#(
  parameter int STRIDE = 1024,
  localparam int COL_W = $clog2(STRIDE),
  localparam int WIDTH_W = COL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH_W-1:0] lineWidth,
  input  logic               inValid,
  output logic               inReady,
  input  logic [7:0]         inIndex,
  input  logic [31:0]        inDirect,
  input  logic [31:0]        inCtrl,
  output logic [7:0]         palIndex,
  input  logic [23:0]        palRgb,
  output logic               outValid,
  input  logic               outReady,
  output logic [23:0]        outRgb,
  output logic               outSol,
  output logic               outEol
);
  scanStrobe_t strobe;

  plane_scan_ctrl #(.STRIDE(STRIDE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .lineWidth(lineWidth),
    .inValid(inValid), .inReady(inReady), .outReady(outReady),
    .outValid(outValid), .outSol(outSol), .outEol(outEol), .strobe(strobe)
  );

  plane_scan_datapath data_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .inIndex(inIndex), .inDirect(inDirect), .inCtrl(inCtrl),
    .palIndex(palIndex), .palRgb(palRgb), .outRgb(outRgb)
  );

  // R1: nothing leaves the stage in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk) $past(!rst_n) |-> !outValid);
endmodule

// File: tb/plane_scan_selector_tb_top.sv
`timescale 1ns/1ps
module plane_scan_selector_tb_top;
  localparam int STRIDE = 16;
  localparam int WIDTH_W = $clog2(STRIDE) + 1;

  logic clk = 0, rst_n = 0;
  logic [WIDTH_W-1:0] lineWidth = WIDTH_W'(STRIDE);
  logic inValid = 0, inReady;
  logic [7:0] inIndex = 0;
  logic [31:0] inDirect = 0, inCtrl = 0;
  logic [7:0] palIndex;
  logic [23:0] palRgb;
  logic outValid, outReady = 1, outSol, outEol;
  logic [23:0] outRgb;

  int checks = 0, errors = 0, benchCol = 0;
  logic [25:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  function automatic logic [23:0] palModel(input logic [7:0] i);
    return {i ^ 8'hC3, i + 8'd17, ~i};
  endfunction
  assign palRgb = palModel(palIndex);

  plane_scan_selector #(.STRIDE(STRIDE)) dut_i (
    .clk(clk), .rst_n(rst_n), .lineWidth(lineWidth),
    .inValid(inValid), .inReady(inReady), .inIndex(inIndex),
    .inDirect(inDirect), .inCtrl(inCtrl), .palIndex(palIndex), .palRgb(palRgb),
    .outValid(outValid), .outReady(outReady), .outRgb(outRgb),
    .outSol(outSol), .outEol(outEol)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard: compares every handshaken output pixel
  always begin
    @(negedge clk); #2;
    if (outValid && outReady) begin
      if (expQ.size() == 0) check(0, "R7 unexpected output", {6'd0, outSol, outEol, outRgb}, 0);
      else begin
        logic [25:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({outSol, outEol, outRgb} == e, t, {6'd0, outSol, outEol, outRgb}, {6'd0, e});
      end
    end
  end

  task automatic sendPixel(input logic [7:0] idx, input logic [31:0] dir, input logic [31:0] ctl, input string tag);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      inValid = 1; inIndex = idx; inDirect = dir; inCtrl = ctl;
      #1 acc = inReady;
      @(posedge clk);
    end
    if (benchCol < int'(lineWidth)) begin
      logic [23:0] rgb;
      rgb = (ctl[31:24] == 8'h03) ? {dir[7:0], dir[15:8], dir[23:16]} : palModel(idx);
      expQ.push_back({benchCol == 0, benchCol == int'(lineWidth) - 1, rgb});
      tagQ.push_back(tag);
    end
    benchCol = (benchCol == STRIDE - 1) ? 0 : benchCol + 1;
    @(negedge clk); inValid = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while (expQ.size() != 0 && guard < 100) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R7 pending pixels", expQ.size(), 0);
  endtask

  task automatic sendLine(input int w, input int kind, input int seed, input string tag);
    lineWidth = WIDTH_W'(w);
    for (int c = 0; c < STRIDE; c++) begin
      logic [7:0] ctlByte;
      case (kind)
        0: ctlByte = 8'h03;
        1: ctlByte = 8'h00;
        default: begin
          case (c % 6) 0: ctlByte = 8'h03; 1: ctlByte = 8'h00; 2: ctlByte = 8'h02;
            3: ctlByte = 8'h83; 4: ctlByte = 8'hFF; default: ctlByte = 8'h13; endcase
        end
      endcase
      sendPixel(8'((c * 37 + seed) & 8'hFF), {8'((seed + c) ^ 8'h5A), 24'((c + 1) * 24'h01F3A7 + seed)},
                {ctlByte, 24'(c * 24'h0A0B0C + seed)}, tag);
    end
  endtask

  task automatic testReset();
    @(negedge clk); #2;
    check(outValid == 0, "R1 outValid after reset", outValid, 0);
    check(inReady == 1, "R1 inReady after reset", inReady, 1);
    lineWidth = WIDTH_W'(STRIDE);
    sendLine(STRIDE, 1, 0, "R1 first line starts at column 0");
    drain();
  endtask

  task automatic testDirect();
    sendLine(10, 0, 7, "R2 direct reorder");
    sendLine(10, 0, 99, "R2 direct reorder second line");
    drain();
  endtask

  task automatic testPalette();
    sendLine(10, 1, 3, "R3 palette lookup");
    drain();
  endtask

  task automatic testCtrlValues();
    sendLine(STRIDE, 2, 11, "R4 tag values");
    sendLine(12, 2, 200, "R4 tag values narrow");
    drain();
  endtask

  task automatic testNarrow();
    sendLine(1, 2, 5, "R8 width one sol and eol");
    sendLine(1, 0, 6, "R8 width one again");
    sendLine(5, 1, 8, "R7 tail dropped");
    drain();
  endtask

  task automatic testFull();
    sendLine(STRIDE, 0, 40, "R9 full width");
    sendLine(STRIDE, 1, 41, "R9 full width palette");
    drain();
  endtask

  task automatic testLatency();
    lineWidth = WIDTH_W'(STRIDE);
    sendPixel(8'h21, 32'h00112233, 32'h03000000, "R5 latency pixel");
    #3 check(outValid == 0, "R5 not valid after accept edge", outValid, 0);
    @(negedge clk); #3;
    check(outValid == 1, "R5 valid after next edge", outValid, 1);
    for (int c = 1; c < STRIDE; c++) sendPixel(8'(c), 32'h0, 32'h0, "R5 filler");
    drain();
  endtask

  task automatic testStall();
    lineWidth = WIDTH_W'(8);
    fork
      for (int c = 0; c < STRIDE; c++)
        sendPixel(8'(c * 5), {8'hEE, 24'(c * 24'h030507)}, {(c % 2) ? 8'h03 : 8'h40, 24'h0}, "R6 stalled line");
      begin
        @(negedge clk); outReady = 0;
        repeat (6) @(negedge clk);
        #3;
        begin
          logic [23:0] held;
          logic hs;
          held = outRgb; hs = outSol;
          check(outValid == 1, "R6 valid held", outValid, 1);
          check(inReady == 0, "R6 inReady low", inReady, 0);
          repeat (3) @(negedge clk);
          #3;
          check(outRgb == held, "R6 rgb stable", outRgb, held);
          check(outSol == hs, "R6 sol stable", outSol, hs);
        end
        @(negedge clk); outReady = 1;
      end
    join
    drain();
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    testReset();
    testDirect();
    testPalette();
    testCtrlValues();
    testNarrow();
    testFull();
    testLatency();
    testStall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule